// File: doc/BRIEF.md
# Banked 256-Word Strobed RAM

This block is a 256-word memory of parameterised width. Every data bit is held by its own group of four 64-word by 1-bit banks, so the default 8-bit width uses thirty-two banks. The low six address bits reach every bank unchanged. The top two address bits pass through a one-hot decoder, and the decoder output is ANDed with the strobe and both enables to form one strobe per bank. Only the bank that has a strobe takes part in an access.

A read answers after a fixed number of clock cycles set by a parameter. The answering bank raises its output enable for that cycle, and every other bank keeps its output idle, which plays the part of high impedance. A one-hot resolver merges the four bank outputs of each bit into one line. When no bank drives a line, or more than one does, the word is flagged invalid and its data reads as zero. The memory array is not cleared by reset. Reset only clears the read pipeline.

Top module: `banked_strobe_ram`

## Requirements
- R1: While reset is held, and on the first cycle after it, `rvalid` is 0 and `rdata` is all zeros.
- R2: A write happens when `strobe`, `en_a` and `en_b` are all 1 and `rd_wrn` is 0 at a rising clock edge. It stores `wdata` at `addr`.
- R3: A read happens when `strobe`, `en_a` and `en_b` are all 1 and `rd_wrn` is 1 at a rising clock edge. `RD_LAT` clock edges later, counting that edge as the first, `rvalid` is 1 for one cycle and `rdata` holds the word stored at that address.
- R4: `addr[7:6]` selects the bank group: value 0 selects bank 0 and value 3 selects bank 3. `addr[5:0]` selects the word inside the bank. All 256 addresses are distinct locations.
- R5: If `strobe`, `en_a` or `en_b` is 0, the cycle performs no access. A write in that cycle leaves memory unchanged. A read in that cycle produces no `rvalid` and leaves `rdata` at zero.
- R6: A write cycle never raises `rvalid`.
- R7: At most one bank drives each bit line. When `rvalid` is 0, `rdata` is all zeros.
- R8: Bit i of `wdata` is stored only in the bank group for bit i. Every bit of a word reads back independently of the others.
- R9: Reads on consecutive cycles are pipelined, and each one returns its own word in order, one per cycle.
- R10: Reset clears a read that is still in flight, but the stored contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all accesses are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read pipeline |
| addr | input | 8 | Word address; [7:6] selects the bank, [5:0] selects the word |
| wdata | input | DATA_W | Write data |
| rd_wrn | input | 1 | 1 selects a read, 0 selects a write |
| strobe | input | 1 | Access strobe |
| en_a | input | 1 | First enable, ANDed with the strobe |
| en_b | input | 1 | Second enable, ANDed with the strobe |
| rdata | output | DATA_W | Read data; zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The checker assumes that `strobe`, `en_a`, `en_b` and `rd_wrn` are free of X and change only away from the rising edge. Its own model of read timing is built from exactly those four signals. The bench drives every input on a falling edge or one time unit after a rising edge, and it resets the design before any access. It reads only addresses it has already written, because the array has no reset and an unwritten word holds no defined value. The single-driver property is checked on the internal per-bank enables rather than on the ports. That is the only place where a decode fault shows up before the resolver masks it.

// File: rtl/banked_strobe_ram_pkg.sv
package banked_strobe_ram_pkg;
   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_READ  = 1'b1
   } ram_op_e;
endpackage

// File: rtl/bank_strobe_decode.sv
module bank_strobe_decode #(
   parameter int SEL_W = 2,
   localparam int BANKS = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             access,
   output logic [BANKS-1:0] bank_stb
);
   // one strobe per bank: decoded select ANDed with the shared access strobe
   always_comb begin
      bank_stb = '0;
      for (int b = 0; b < BANKS; b++) begin
         bank_stb[b] = access && (sel == SEL_W'(b));
      end
   end
endmodule

// File: rtl/ram_bit_bank.sv
module ram_bit_bank #(
   parameter int WORD_AW = 6,
   parameter int RD_LAT  = 2,
   localparam int WORDS  = 1 << WORD_AW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bank_stb,
   input  logic               rd_wrn,
   input  logic [WORD_AW-1:0] word_addr,
   input  logic               wbit,
   output logic               q,
   output logic               q_oe
);
   import banked_strobe_ram_pkg::*;

   logic             mem [WORDS];
   logic [RD_LAT-1:0] v_q;
   logic [RD_LAT-1:0] d_q;
   logic              rd_req;
   logic              wr_req;

   assign rd_req = bank_stb && (rd_wrn == OP_READ);
   assign wr_req = bank_stb && (rd_wrn == OP_WRITE);

   // storage has no reset: contents survive a pipeline reset
   always_ff @(posedge clk) begin
      if (wr_req) begin
         mem[word_addr] <= wbit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
         d_q <= '0;
      end else begin
         v_q[0] <= rd_req;
         d_q[0] <= rd_req ? mem[word_addr] : 1'b0;
         for (int s = 1; s < RD_LAT; s++) begin
            v_q[s] <= v_q[s-1];
            d_q[s] <= d_q[s-1];
         end
      end
   end

   // an idle bank presents a released line (modelled as 0, enable low)
   assign q_oe = v_q[RD_LAT-1];
   assign q    = v_q[RD_LAT-1] & d_q[RD_LAT-1];
endmodule

// File: rtl/wired_bus_resolve.sv
module wired_bus_resolve #(
   parameter int BANKS = 4
) (
   input  logic [BANKS-1:0] oe,
   input  logic [BANKS-1:0] q,
   output logic             line,
   output logic             line_ok
);
   generate
      if (BANKS == 1) begin : g_single
         assign line_ok = oe[0];
         assign line    = oe[0] & q[0];
      end else begin : g_multi
         // exactly one driver gives a defined line; none or contention does not
         assign line_ok = $onehot(oe);
         assign line    = line_ok & (|(oe & q));
      end
   endgenerate
endmodule

// File: rtl/banked_strobe_ram.sv
module banked_strobe_ram #(
   parameter int DATA_W  = 8,
   parameter int SEL_W   = 2,
   parameter int WORD_AW = 6,
   parameter int RD_LAT  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [SEL_W+WORD_AW-1:0]   addr,
   input  logic [DATA_W-1:0]          wdata,
   input  logic                       rd_wrn,
   input  logic                       strobe,
   input  logic                       en_a,
   input  logic                       en_b,
   output logic [DATA_W-1:0]          rdata,
   output logic                       rvalid
);
   localparam int BANKS  = 1 << SEL_W;
   localparam int ADDR_W = SEL_W + WORD_AW;

   generate
      if (DATA_W < 1)              begin : g_bad_w   $error("DATA_W must be at least 1");      end
      if (SEL_W < 1 || SEL_W > 4)  begin : g_bad_s   $error("SEL_W must be 1..4");             end
      if (WORD_AW < 1 || WORD_AW > 10) begin : g_bad_a $error("WORD_AW must be 1..10");        end
      if (RD_LAT < 1 || RD_LAT > 8) begin : g_bad_l  $error("RD_LAT must be 1..8");            end
   endgenerate

   logic                      access;
   logic [BANKS-1:0]          bank_stb;
   logic [SEL_W-1:0]          bank_sel;
   logic [WORD_AW-1:0]        word_addr;
   logic [DATA_W-1:0]         line_val;
   logic [DATA_W-1:0]         line_ok;
   logic [DATA_W*BANKS-1:0]   bank_oe_flat;
   logic [DATA_W*BANKS-1:0]   bank_q_flat;

   assign access    = strobe & en_a & en_b;
   assign bank_sel  = addr[ADDR_W-1:WORD_AW];
   assign word_addr = addr[WORD_AW-1:0];

   bank_strobe_decode #(.SEL_W(SEL_W)) dec_i (
      .sel      (bank_sel),
      .access   (access),
      .bank_stb (bank_stb)
   );

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         ram_bit_bank #(.WORD_AW(WORD_AW), .RD_LAT(RD_LAT)) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .bank_stb  (bank_stb[b]),
            .rd_wrn    (rd_wrn),
            .word_addr (word_addr),
            .wbit      (wdata[i]),
            .q         (bank_q_flat[i*BANKS + b]),
            .q_oe      (bank_oe_flat[i*BANKS + b])
         );
      end
      wired_bus_resolve #(.BANKS(BANKS)) res_i (
         .oe      (bank_oe_flat[i*BANKS +: BANKS]),
         .q       (bank_q_flat[i*BANKS +: BANKS]),
         .line    (line_val[i]),
         .line_ok (line_ok[i])
      );
   end

   assign rvalid = &line_ok;
   assign rdata  = rvalid ? line_val : '0;
endmodule

// File: rtl/banked_strobe_ram_chk.sv
module banked_strobe_ram_chk #(
   parameter int DATA_W = 8,
   parameter int BANKS  = 4,
   parameter int RD_LAT = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     strobe,
   input logic                     en_a,
   input logic                     en_b,
   input logic                     rd_wrn,
   input logic                     rvalid,
   input logic [DATA_W-1:0]        rdata,
   input logic [DATA_W*BANKS-1:0]  bank_oe
);
   // independent model of when a read answer is due, built from the ports
   logic [RD_LAT-1:0] due_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         due_q <= '0;
      end else begin
         due_q[0] <= strobe & en_a & en_b & rd_wrn;
         for (int s = 1; s < RD_LAT; s++) begin
            due_q[s] <= due_q[s-1];
         end
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!rvalid && rdata == '0));

   // R3, R5, R6: valid appears exactly when a read was issued RD_LAT edges earlier
   assert_valid_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid == due_q[RD_LAT-1]);

   assert_invalid_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> rdata == '0);

   for (genvar g = 0; g < DATA_W; g++) begin : g_line
      assert_single_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(bank_oe[g*BANKS +: BANKS]));
   end
endmodule

bind banked_strobe_ram banked_strobe_ram_chk #(
   .DATA_W (DATA_W),
   .BANKS  (1 << SEL_W),
   .RD_LAT (RD_LAT)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .strobe  (strobe),
   .en_a    (en_a),
   .en_b    (en_b),
   .rd_wrn  (rd_wrn),
   .rvalid  (rvalid),
   .rdata   (rdata),
   .bank_oe (bank_oe_flat)
);

// File: tb/banked_strobe_ram_tb_top.sv
module banked_strobe_ram_tb_top;
   localparam int DATA_W = 8;
   localparam int RD_LAT = 2;
   localparam int NROWS  = 12;

   // row: [28] read, [27:20] addr, [19:12] wdata, [11] strobe, [10] en_a,
   //      [9] en_b, [8] expected valid, [7:0] expected data
   localparam logic [28:0] ROWS [NROWS] = '{
      {1'b0, 8'h00, 8'h11, 3'b111, 1'b0, 8'h00},
      {1'b1, 8'h00, 8'h00, 3'b111, 1'b1, 8'h11},
      {1'b0, 8'h40, 8'h22, 3'b111, 1'b0, 8'h00},
      {1'b1, 8'h40, 8'h00, 3'b111, 1'b1, 8'h22},
      {1'b1, 8'h00, 8'h00, 3'b111, 1'b1, 8'h11},
      {1'b0, 8'h00, 8'h99, 3'b101, 1'b0, 8'h00},
      {1'b1, 8'h00, 8'h00, 3'b111, 1'b1, 8'h11},
      {1'b0, 8'hC0, 8'h33, 3'b111, 1'b0, 8'h00},
      {1'b1, 8'hC0, 8'h00, 3'b011, 1'b0, 8'h00},
      {1'b0, 8'hFF, 8'h44, 3'b111, 1'b0, 8'h00},
      {1'b1, 8'hFF, 8'h00, 3'b111, 1'b1, 8'h44},
      {1'b1, 8'h3F, 8'h00, 3'b110, 1'b0, 8'h00}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [7:0]        addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic              rd_wrn = 1'b1;
   logic              strobe = 1'b0;
   logic              en_a = 1'b0;
   logic              en_b = 1'b0;
   logic [DATA_W-1:0] rdata;
   logic              rvalid;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] ref_mem [256];

   always #5 clk = ~clk;

   banked_strobe_ram #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_wrn(rd_wrn),
      .strobe(strobe), .en_a(en_a), .en_b(en_b), .rdata(rdata), .rvalid(rvalid)
   );

   function automatic string row_req(int i);
      case (i)
         0, 2, 9: return "R6";
         3, 4:    return "R4";
         5, 6:    return "R5";
         8, 11:   return "R5";
         default: return "R3";
      endcase
   endfunction

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37 + 8'h5B) % 256);
   endfunction

   task automatic check(string req, logic v, logic [7:0] d, logic ev, logic [7:0] ed);
      n_tests++;
      if (v !== ev || d !== ed) begin
         n_fail++;
         $display("FAIL %s: rvalid=%0b rdata=%02h expected rvalid=%0b rdata=%02h",
                  req, v, d, ev, ed);
      end
   endtask

   // one access, then sample when its answer is due
   task automatic access(logic rd, logic [7:0] a, logic [7:0] d, logic [2:0] ctl,
                         output logic v, output logic [7:0] q);
      @(negedge clk);
      rd_wrn = rd; addr = a; wdata = d;
      {strobe, en_a, en_b} = ctl;
      @(posedge clk);
      #1 strobe = 1'b0;
      repeat (RD_LAT - 1) @(posedge clk);
      @(negedge clk);
      v = rvalid; q = rdata;
   endtask

   initial begin
      logic       v;
      logic [7:0] q;
      repeat (3) @(negedge clk);
      check("R1", rvalid, rdata, 1'b0, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", rvalid, rdata, 1'b0, 8'h00);

      for (int i = 0; i < NROWS; i++) begin
         access(ROWS[i][28], ROWS[i][27:20], ROWS[i][19:12], ROWS[i][11:9], v, q);
         check(row_req(i), v, q, ROWS[i][8], ROWS[i][7:0]);
      end

      // R2 R4 R8: fill every address with a distinct pattern
      for (int a = 0; a < 256; a++) begin
         ref_mem[a] = pat(a);
         access(1'b0, 8'(a), pat(a), 3'b111, v, q);
      end

      // R9: back-to-back pipelined reads of all 256 words
      for (int s = 0; s < 256 + RD_LAT; s++) begin
         @(negedge clk);
         if (s >= RD_LAT) check("R9", rvalid, rdata, 1'b1, ref_mem[s - RD_LAT]);
         if (s < 256) begin
            rd_wrn = 1'b1; addr = 8'(s); {strobe, en_a, en_b} = 3'b111;
         end else begin
            strobe = 1'b0;
         end
      end

      // R8: single-bit words per bank check bit independence
      access(1'b0, 8'h81, 8'h80, 3'b111, v, q);
      access(1'b0, 8'h82, 8'h01, 3'b111, v, q);
      access(1'b1, 8'h81, 8'h00, 3'b111, v, q);
      check("R8", v, q, 1'b1, 8'h80);
      access(1'b1, 8'h82, 8'h00, 3'b111, v, q);
      check("R8", v, q, 1'b1, 8'h01);

      // R10: reset kills a read in flight; storage survives
      @(negedge clk);
      rd_wrn = 1'b1; addr = 8'h82; {strobe, en_a, en_b} = 3'b111;
      @(posedge clk);
      #1 strobe = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      check("R10", rvalid, rdata, 1'b0, 8'h00);
      @(negedge clk);
      check("R10", rvalid, rdata, 1'b0, 8'h00);
      rst_n = 1'b1;
      access(1'b1, 8'h82, 8'h00, 3'b111, v, q);
      check("R10", v, q, 1'b1, 8'h01);
      access(1'b1, 8'hC5, 8'h00, 3'b111, v, q);
      check("R10", v, q, 1'b1, ref_mem[8'hC5]);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1_500_000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule